// File: doc/BRIEF.md
# Reset Cause Event Aggregator

This block gathers single-cycle reset-cause strobes from up to sixteen sources and folds those that land close together into one event record. The first strobe opens an event and starts a concurrency window counted in millisecond ticks. Every strobe seen before the window closes is OR-ed into the same cause bitmap. For each cause bit the block records the order in which it arrived. When the window closes the block publishes the record, which carries:

- the bitmap,
- a priority summary code,
- a strictly increasing sequence number,
- the ticks elapsed since the previous event,
- an arrival count and the index of the first cause,
- a repeat counter.

A second, longer suppression window starts when an event is emitted. While it runs, an event whose bitmap equals the last emitted one is not logged again. Instead, the repeat counter of the last record is bumped. The record is held with a valid flag until the consumer acknowledges it. Until then no new event is emitted, and the next event keeps collecting causes. Record fields stay readable after the acknowledge.

Top module: `rstc_evt_agg`

## Requirements
- R1: Bitmap positions are fixed: bit 0 power-on, 1 brown-out, 2 watchdog, 3 external pin, 4 software, 5 thermal, 6 power-good loss, 7 core lockup, 8–15 auxiliary. A strobe on input bit i sets bitmap bit i of the event it falls into.
- R2: An event opens on the first strobe while idle and latches `win_len` = N. It closes on the first cycle after N ticks have been counted (N = 0 closes it on the next cycle). Strobes up to and including the closing cycle merge into that event. A strobe after the close opens a new event.
- R3: `evt_summary` is the bit index of the highest-priority set cause. The order is lockup (7), thermal (5), brown-out (1), power-good loss (6), watchdog (2), external (3), software (4), power-on (0). The value is 5'h1F when none of bits 0–7 is set.
- R4: The summary is never software (4) while any of bits 1, 2, 3, 5, 6 or 7 is set in the same event.
- R5: `evt_order[4i+3:4i]` is the arrival rank of bit i. Rank 0 is the opening cycle, and each later cycle that adds new bits takes the next rank, saturating at 15. Bits arriving in the same cycle share a rank, and unset bits read 0. `evt_arrivals` counts the cycles that added bits. `evt_first` is the lowest-indexed bit of the opening strobe.
- R6: An event closing with a bitmap equal to the last emitted one, while the suppression window is running, is not emitted. The suppression window is `sup_len` ticks latched at open and started at emission. Instead, `evt_repeat` increments, saturating at 255. Emission clears `evt_repeat` to 0.
- R7: `evt_seq` is 0 after reset, and the first emitted event carries 1. Each emission adds exactly 1, saturating at all ones, so the value never decreases.
- R8: `evt_dticks` holds the ticks counted from the previous emission cycle, inclusive, to this emission cycle, exclusive. For the first event it counts from reset.
- R9: `evt_valid` rises one cycle after the closing cycle and holds, with bitmap, summary and sequence stable, until a cycle with `evt_ack` high. While it is high, a closing non-duplicate event waits and keeps merging strobes.
- R10: After reset, `evt_valid`, `evt_causes`, `evt_seq` and `evt_repeat` are all 0.
- R11: Changing `win_len` while an event is open does not change that event's window length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cause_stb | input | 16 | Single-cycle cause strobes, one per bitmap position |
| ms_tick | input | 1 | One-cycle millisecond tick enable |
| win_len | input | 8 | Concurrency window length in ticks |
| sup_len | input | 8 | Suppression window length in ticks |
| evt_ack | input | 1 | Consumer acknowledge of the held record |
| evt_valid | output | 1 | Record pending acknowledge |
| evt_causes | output | 16 | Merged cause bitmap |
| evt_summary | output | 5 | Highest-priority cause index, 5'h1F if none |
| evt_first | output | 4 | Lowest bit index of the opening strobe |
| evt_arrivals | output | 5 | Number of cycles that added cause bits |
| evt_order | output | 64 | Per-bit arrival rank, 4 bits per cause |
| evt_seq | output | 16 | Event sequence number |
| evt_dticks | output | 16 | Ticks since previous emission |
| evt_repeat | output | 8 | Suppressed duplicate count for the last record |

## Verification
The properties assume that strobes, ticks and acknowledges are sampled only on clock edges. They also assume that strobes, ticks and acknowledges are single-cycle qualifiers, and that the window lengths are constant or irrelevant outside the opening cycle. The stimulus drives every input half a cycle away from the active edge and changes the window lengths only at the start of a 500-cycle segment. It also repeats the last strobe pattern often enough that duplicates fall inside and outside the suppression window. Directed runs cover the cases that random stimulus reaches rarely: a brown-out following a power-good loss, software mixed with watchdog, a close that must wait for a pending acknowledge, and a repeat count driven past saturation.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int unsigned C_POR    = 0;
  localparam int unsigned C_BOR    = 1;
  localparam int unsigned C_WDT    = 2;
  localparam int unsigned C_EXT    = 3;
  localparam int unsigned C_SOFT   = 4;
  localparam int unsigned C_THERM  = 5;
  localparam int unsigned C_PGF    = 6;
  localparam int unsigned C_LOCKUP = 7;

  localparam int unsigned N_RANKED = 8;
  // Highest priority first.
  localparam logic [2:0] RANKED [N_RANKED] = '{3'd7, 3'd5, 3'd1, 3'd6, 3'd2, 3'd3, 3'd4, 3'd0};
  localparam logic [4:0] SUM_NONE = 5'h1F;
  localparam logic [7:0] HW_MASK  = 8'hEE;

  typedef enum logic [0:0] {AG_IDLE, AG_OPEN} agg_state_e;
endpackage

// File: rtl/rstc_tick_timer.sv
module rstc_tick_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  input  logic         tick,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                    cnt_d = len;
    else if (tick && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/rstc_order_trk.sv
module rstc_order_trk #(
  parameter int unsigned NSRC   = 16,
  parameter int unsigned RANK_W = 4,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   merge,
  input  logic [NSRC-1:0]        stb,
  output logic [NSRC-1:0]        acc_nx,
  output logic [NSRC*RANK_W-1:0] order_nx,
  output logic [IDX_W-1:0]       first_nx,
  output logic [IDX_W:0]         arr_nx
);
  localparam int unsigned RANK_MAXI = (1 << RANK_W) - 1;
  localparam logic [IDX_W:0] ARR_MAX = (IDX_W+1)'(NSRC);

  logic [NSRC-1:0]   acc_q, fresh;
  logic [IDX_W:0]    arr_q;
  logic [IDX_W-1:0]  first_q, low_idx;
  logic [RANK_W-1:0] next_rank;

  assign fresh = start ? stb : (merge ? (stb & ~acc_q) : '0);

  always_comb begin
    low_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (stb[i]) low_idx = IDX_W'(i);
  end

  always_comb begin
    if (start)                                    next_rank = '0;
    else if (arr_q >= (IDX_W+1)'(RANK_MAXI))      next_rank = RANK_W'(RANK_MAXI);
    else                                          next_rank = RANK_W'(arr_q);
  end

  always_comb begin
    acc_nx   = start ? stb : (acc_q | fresh);
    first_nx = start ? low_idx : first_q;
    if (start)                          arr_nx = (|stb) ? (IDX_W+1)'(1) : '0;
    else if (|fresh && arr_q != ARR_MAX) arr_nx = arr_q + 1'b1;
    else                                arr_nx = arr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      arr_q   <= '0;
      first_q <= '0;
    end else begin
      acc_q   <= acc_nx;
      arr_q   <= arr_nx;
      first_q <= first_nx;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_rank
    logic [RANK_W-1:0] rank_q, rank_d;
    always_comb begin
      if (start)         rank_d = '0;
      else if (fresh[g]) rank_d = next_rank;
      else               rank_d = rank_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rank_q <= '0;
      else        rank_q <= rank_d;
    end
    assign order_nx[g*RANK_W +: RANK_W] = rank_d;
  end
endmodule

// File: rtl/rstc_prio.sv
module rstc_prio
  import rstc_pkg::*;
(
  input  logic [N_RANKED-1:0] std_causes,
  output logic [4:0]          code
);
  always_comb begin
    code = SUM_NONE;
    for (int k = N_RANKED - 1; k >= 0; k--)
      if (std_causes[RANKED[k]]) code = {2'b00, RANKED[k]};
  end
endmodule

// File: rtl/rstc_evt_agg.sv
module rstc_evt_agg
  import rstc_pkg::*;
#(
  parameter int unsigned NSRC   = 16,
  parameter int unsigned WIN_W  = 8,
  parameter int unsigned SEQ_W  = 16,
  parameter int unsigned DT_W   = 16,
  parameter int unsigned REP_W  = 8,
  parameter int unsigned RANK_W = 4,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        cause_stb,
  input  logic                   ms_tick,
  input  logic [WIN_W-1:0]       win_len,
  input  logic [WIN_W-1:0]       sup_len,
  input  logic                   evt_ack,
  output logic                   evt_valid,
  output logic [NSRC-1:0]        evt_causes,
  output logic [4:0]             evt_summary,
  output logic [IDX_W-1:0]       evt_first,
  output logic [IDX_W:0]         evt_arrivals,
  output logic [NSRC*RANK_W-1:0] evt_order,
  output logic [SEQ_W-1:0]       evt_seq,
  output logic [DT_W-1:0]        evt_dticks,
  output logic [REP_W-1:0]       evt_repeat
);
  agg_state_e state_q, state_d;

  logic                   start, merge, win_done, sup_done, closing, dup, emit, suppress;
  logic [NSRC-1:0]        acc_nx;
  logic [NSRC*RANK_W-1:0] order_nx;
  logic [IDX_W-1:0]       first_nx;
  logic [IDX_W:0]         arr_nx;
  logic [4:0]             sum_nx;
  logic [WIN_W-1:0]       sup_lat_q, sup_lat_d;
  logic [DT_W-1:0]        since_q, since_d;

  logic                   valid_q, valid_d;
  logic [NSRC-1:0]        causes_q, causes_d;
  logic [4:0]             sum_q, sum_d;
  logic [IDX_W-1:0]       first_q, first_d;
  logic [IDX_W:0]         arr_q, arr_d;
  logic [NSRC*RANK_W-1:0] order_q, order_d;
  logic [SEQ_W-1:0]       seq_q, seq_d;
  logic [DT_W-1:0]        dt_q, dt_d;
  logic [REP_W-1:0]       rep_q, rep_d;

  assign start = (state_q == AG_IDLE) && (|cause_stb);
  assign merge = (state_q == AG_OPEN);

  rstc_order_trk #(.NSRC(NSRC), .RANK_W(RANK_W)) u_order (
    .clk(clk), .rst_n(rst_n), .start(start), .merge(merge), .stb(cause_stb),
    .acc_nx(acc_nx), .order_nx(order_nx), .first_nx(first_nx), .arr_nx(arr_nx)
  );

  rstc_tick_timer #(.W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .load(start), .len(win_len), .tick(ms_tick), .done(win_done)
  );

  rstc_tick_timer #(.W(WIN_W)) u_sup (
    .clk(clk), .rst_n(rst_n), .load(emit), .len(sup_lat_q), .tick(ms_tick), .done(sup_done)
  );

  rstc_prio u_prio (.std_causes(acc_nx[N_RANKED-1:0]), .code(sum_nx));

  // Sequence 0 is the reset anchor, so a nonzero value marks a prior emission.
  assign closing  = merge && win_done;
  assign dup      = (seq_q != '0) && !sup_done && (acc_nx == causes_q);
  assign suppress = closing && dup;
  assign emit     = closing && !dup && !valid_q;

  always_comb begin
    state_d = state_q;
    if (start)                 state_d = AG_OPEN;
    else if (emit || suppress) state_d = AG_IDLE;
  end

  always_comb begin
    sup_lat_d = start ? sup_len : sup_lat_q;
    if (emit)                           since_d = DT_W'(ms_tick);
    else if (ms_tick && !(&since_q))    since_d = since_q + 1'b1;
    else                                since_d = since_q;
  end

  always_comb begin
    valid_d  = valid_q;
    causes_d = causes_q;
    sum_d    = sum_q;
    first_d  = first_q;
    arr_d    = arr_q;
    order_d  = order_q;
    seq_d    = seq_q;
    dt_d     = dt_q;
    rep_d    = rep_q;
    if (emit) begin
      valid_d  = 1'b1;
      causes_d = acc_nx;
      sum_d    = sum_nx;
      first_d  = first_nx;
      arr_d    = arr_nx;
      order_d  = order_nx;
      seq_d    = (&seq_q) ? seq_q : seq_q + 1'b1;
      dt_d     = since_q;
      rep_d    = '0;
    end else begin
      if (valid_q && evt_ack)       valid_d = 1'b0;
      if (suppress && !(&rep_q))    rep_d   = rep_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= AG_IDLE;
      sup_lat_q <= '0;
      since_q   <= '0;
      valid_q   <= 1'b0;
      causes_q  <= '0;
      sum_q     <= SUM_NONE;
      first_q   <= '0;
      arr_q     <= '0;
      order_q   <= '0;
      seq_q     <= '0;
      dt_q      <= '0;
      rep_q     <= '0;
    end else begin
      state_q   <= state_d;
      sup_lat_q <= sup_lat_d;
      since_q   <= since_d;
      valid_q   <= valid_d;
      causes_q  <= causes_d;
      sum_q     <= sum_d;
      first_q   <= first_d;
      arr_q     <= arr_d;
      order_q   <= order_d;
      seq_q     <= seq_d;
      dt_q      <= dt_d;
      rep_q     <= rep_d;
    end
  end

  assign evt_valid    = valid_q;
  assign evt_causes   = causes_q;
  assign evt_summary  = sum_q;
  assign evt_first    = first_q;
  assign evt_arrivals = arr_q;
  assign evt_order    = order_q;
  assign evt_seq      = seq_q;
  assign evt_dticks   = dt_q;
  assign evt_repeat   = rep_q;
endmodule

// File: rtl/rstc_evt_agg_chk.sv
module rstc_evt_agg_chk
  import rstc_pkg::*;
#(
  parameter int unsigned NSRC  = 16,
  parameter int unsigned SEQ_W = 16,
  parameter int unsigned REP_W = 8,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_ack,
  input logic             evt_valid,
  input logic [NSRC-1:0]  evt_causes,
  input logic [4:0]       evt_summary,
  input logic [IDX_W-1:0] evt_first,
  input logic [IDX_W:0]   evt_arrivals,
  input logic [SEQ_W-1:0] evt_seq,
  input logic [REP_W-1:0] evt_repeat
);
  p_hold_until_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ack) |=> (evt_valid && $stable(evt_causes) && $stable(evt_seq) && $stable(evt_summary)));

  p_seq_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_valid) |-> ((evt_seq == SEQ_W'($past(evt_seq) + 1'b1)) || (&$past(evt_seq))));

  p_seq_forward_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(evt_seq) |-> (evt_seq > $past(evt_seq)));

  p_seq_anchor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_seq != '0));

  p_soft_not_hiding_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_summary == 5'(C_SOFT)) |-> ((evt_causes[7:0] & HW_MASK) == 8'h00));

  p_summary_member_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_summary != SUM_NONE) |-> evt_causes[evt_summary[2:0]]);

  p_first_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_causes[evt_first] && evt_arrivals != '0));

  p_repeat_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (&evt_repeat) |=> ((&evt_repeat) || $rose(evt_valid)));
endmodule

bind rstc_evt_agg rstc_evt_agg_chk #(.NSRC(NSRC), .SEQ_W(SEQ_W), .REP_W(REP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_ack(evt_ack), .evt_valid(evt_valid),
  .evt_causes(evt_causes), .evt_summary(evt_summary), .evt_first(evt_first),
  .evt_arrivals(evt_arrivals), .evt_seq(evt_seq), .evt_repeat(evt_repeat)
);

// File: tb/rstc_evt_agg_bench.sv
`timescale 1ns/1ps
module rstc_evt_agg_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cause_stb;
  logic        ms_tick, evt_ack;
  logic [7:0]  win_len, sup_len;
  logic        evt_valid;
  logic [15:0] evt_causes;
  logic [4:0]  evt_summary;
  logic [3:0]  evt_first;
  logic [4:0]  evt_arrivals;
  logic [63:0] evt_order;
  logic [15:0] evt_seq, evt_dticks;
  logic [7:0]  evt_repeat;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rstc_evt_agg u_rstc_evt_agg (
    .clk(clk), .rst_n(rst_n), .cause_stb(cause_stb), .ms_tick(ms_tick),
    .win_len(win_len), .sup_len(sup_len), .evt_ack(evt_ack),
    .evt_valid(evt_valid), .evt_causes(evt_causes), .evt_summary(evt_summary),
    .evt_first(evt_first), .evt_arrivals(evt_arrivals), .evt_order(evt_order),
    .evt_seq(evt_seq), .evt_dticks(evt_dticks), .evt_repeat(evt_repeat)
  );

  // Reference state, written from the requirements.
  bit        m_open, m_valid;
  int        m_wcnt, m_scnt, m_slat, m_since;
  bit [15:0] m_acc, m_causes;
  int        m_rank [16];
  int        m_erank [16];
  int        m_nar, m_first, m_sum, m_efirst, m_earr, m_seq, m_dt, m_rep;

  function automatic int prio_of(bit [15:0] c);
    int order [8] = '{7, 5, 1, 6, 2, 3, 4, 0};
    for (int k = 0; k < 8; k++) if (c[order[k]]) return order[k];
    return 31;
  endfunction

  function automatic int lowest(bit [15:0] c);
    for (int i = 0; i < 16; i++) if (c[i]) return i;
    return 0;
  endfunction

  task automatic model_reset();
    m_open = 0; m_valid = 0; m_wcnt = 0; m_scnt = 0; m_slat = 0; m_since = 0;
    m_acc = '0; m_causes = '0; m_nar = 0; m_first = 0; m_sum = 31; m_efirst = 0;
    m_earr = 0; m_seq = 0; m_dt = 0; m_rep = 0;
    for (int i = 0; i < 16; i++) begin m_rank[i] = 0; m_erank[i] = 0; end
  endtask

  task automatic model_step(bit [15:0] s, bit t, bit a, int wl, int sl);
    bit was_open = m_open;
    bit old_valid = m_valid;
    int old_scnt = m_scnt;
    int old_since = m_since;
    bit emit = 0;
    if (!was_open) begin
      if (s != 0) begin
        m_open = 1; m_wcnt = wl; m_slat = sl; m_acc = s; m_nar = 1; m_first = lowest(s);
        for (int i = 0; i < 16; i++) m_rank[i] = 0;
      end
    end else begin
      bit [15:0] nb = s & ~m_acc;
      if (nb != 0) begin
        for (int i = 0; i < 16; i++) if (nb[i]) m_rank[i] = (m_nar > 15) ? 15 : m_nar;
        m_nar++;
        m_acc |= nb;
      end
      if (m_wcnt == 0) begin
        if (m_seq != 0 && old_scnt != 0 && m_acc == m_causes) begin
          m_open = 0;
          if (m_rep < 255) m_rep++;
        end else if (!old_valid) begin
          emit = 1; m_open = 0; m_valid = 1; m_causes = m_acc; m_sum = prio_of(m_acc);
          m_efirst = m_first; m_earr = m_nar; m_erank = m_rank;
          if (m_seq < 65535) m_seq++;
          m_dt = old_since; m_rep = 0;
        end
      end
      if (t && m_wcnt > 0) m_wcnt--;
    end
    if (emit) m_scnt = m_slat; else if (t && m_scnt > 0) m_scnt--;
    if (emit) m_since = t; else if (t && m_since < 65535) m_since++;
    if (!emit && old_valid && a) m_valid = 0;
  endtask

  task automatic chk(string tag, longint got, longint exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R9 valid", evt_valid, m_valid);
    chk("R7 sequence", evt_seq, m_seq);
    chk("R6 repeat", evt_repeat, m_rep);
    if (m_seq != 0) begin
      chk("R1/R2 bitmap", evt_causes, m_causes);
      chk("R3 summary", evt_summary, m_sum);
      chk("R5 first", evt_first, m_efirst);
      chk("R5 arrivals", evt_arrivals, m_earr);
      chk("R8 dticks", evt_dticks, m_dt);
      for (int i = 0; i < 16; i++) chk("R5 rank", evt_order[4*i +: 4], m_erank[i]);
    end
  endtask

  task automatic cyc(input logic [15:0] s, input logic t, input logic a);
    cause_stb = s; ms_tick = t; evt_ack = a;
    @(posedge clk);
    model_step(s, t, a, int'(win_len), int'(sup_len));
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] last_pat;
    int unsigned seed_set;
    seed_set = $urandom(32'h00C0FFEE);
    rst_n = 1'b0; cause_stb = '0; ms_tick = 0; evt_ack = 0; win_len = 8'd3; sup_len = 8'd0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 valid", evt_valid, 0);
    chk("R10 seq", evt_seq, 0);
    chk("R10 causes", evt_causes, 0);
    chk("R10 repeat", evt_repeat, 0);

    // R5/R2: power-good loss then brown-out inside one window
    cyc(16'h0040, 0, 0);
    cyc(16'h0000, 1, 0);
    cyc(16'h0002, 0, 0);
    cyc(16'h0000, 1, 0);
    cyc(16'h0000, 1, 0);
    cyc(16'h0000, 0, 0);
    chk("R2 merged valid", evt_valid, 1);
    chk("R2 merged bitmap", evt_causes, 16'h0042);
    chk("R3 brown-out wins", evt_summary, 1);
    chk("R5 first pgfail", evt_first, 6);
    chk("R5 two arrivals", evt_arrivals, 2);
    chk("R5 pgfail rank", evt_order[27:24], 0);
    chk("R5 brownout rank", evt_order[7:4], 1);
    chk("R7 first seq", evt_seq, 1);
    chk("R8 ticks since reset", evt_dticks, 3);
    cyc(16'h0000, 0, 1);
    chk("R9 ack clears", evt_valid, 0);

    // R4: software with watchdog, then software alone, then auxiliary only
    win_len = 8'd0;
    cyc(16'h0014, 0, 0); cyc(16'h0000, 0, 0);
    chk("R4 watchdog over soft", evt_summary, 2);
    cyc(16'h0000, 0, 1);
    cyc(16'h0010, 0, 0); cyc(16'h0000, 0, 0);
    chk("R3 soft alone", evt_summary, 4);
    cyc(16'h0000, 0, 1);
    cyc(16'h8000, 0, 0); cyc(16'h0000, 0, 0);
    chk("R3 none code", evt_summary, 5'h1F);
    chk("R1 custom bit", evt_causes, 16'h8000);
    // R2: strobe after close starts a new event
    cyc(16'h0001, 0, 1); cyc(16'h0000, 0, 0);
    chk("R2 new event bitmap", evt_causes, 16'h0001);
    chk("R7 seq step", evt_seq, 5);

    // R9: close deferred while pending, later strobe merges
    cyc(16'h0020, 0, 0);
    cyc(16'h0000, 0, 0);
    cyc(16'h0080, 0, 0);
    chk("R9 pending bitmap held", evt_causes, 16'h0001);
    cyc(16'h0000, 0, 1);
    cyc(16'h0000, 0, 0);
    chk("R9 deferred bitmap", evt_causes, 16'h00A0);
    chk("R3 lockup wins", evt_summary, 7);
    cyc(16'h0000, 0, 1);

    // R11: window length latched at open
    win_len = 8'd2;
    cyc(16'h0004, 0, 0);
    win_len = 8'd9;
    cyc(16'h0000, 1, 0);
    cyc(16'h0000, 1, 0);
    cyc(16'h0000, 0, 0);
    chk("R11 closed on latched length", evt_valid, 1);
    cyc(16'h0000, 0, 1);

    // R6: duplicates counted, saturating
    win_len = 8'd0; sup_len = 8'd200;
    cyc(16'h0008, 0, 0); cyc(16'h0000, 0, 0); cyc(16'h0000, 0, 1);
    cyc(16'h0008, 0, 0); cyc(16'h0000, 0, 0);
    chk("R6 first repeat", evt_repeat, 1);
    chk("R6 no new event", evt_valid, 0);
    for (int n = 0; n < 260; n++) begin
      cyc(16'h0008, 0, 0); cyc(16'h0000, 0, 0);
    end
    chk("R6 repeat saturates", evt_repeat, 255);
    chk("R7 seq unchanged by repeats", evt_seq, 8);

    // Random phase
    last_pat = 16'h0008;
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] s;
      s = '0;
      if (n % 500 == 0) begin
        win_len = 8'($urandom_range(0, 5));
        sup_len = 8'($urandom_range(0, 30));
      end
      if ($urandom_range(0, 9) == 0)
        s = ($urandom_range(0, 2) == 0) ? last_pat : (16'($urandom) & 16'($urandom));
      if (s != 0) last_pat = s;
      cyc(s, $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule